// File: doc/BRIEF.md
# Pre-Trigger Circular Capture Buffer

This block stores a stream of samples in an on-chip RAM that it uses as a ring while it waits for a trigger. When a trigger sample is accepted, the block writes a programmed number of further samples and then freezes. The samples that were written before the trigger therefore stay in the ring. A readout port rotates addresses so that logical index 0 is the oldest stored sample and index DEPTH-1 is the newest. A rearm request starts a hold-off interval. During that interval triggers have no effect, and when it ends the block returns to waiting.

The sample input is a valid/ready stream. `s_ready` is always high, so the block never applies back-pressure. A beat is taken only while the block is armed or counting post-trigger samples. A beat offered in any other state is accepted and dropped. The trigger qualifies the beat that carries it. Any fixed latency between the real event and `trig` must be absorbed by the chosen post-trigger length. The post-trigger length counts the trigger sample itself, so the pre-trigger depth is DEPTH minus that length.

Top module: `capbuf_top`

## Requirements
- R1: After reset, `armed`, `done` and `partial` are 0, `trig_addr` is 0, the write location is 0 and `s_ready` is 1.
- R2: An `arm` pulse in the idle state raises `armed` on the next clock edge. `cfg_post` is latched on `arm` and on `rearm`, and is clamped so that 0 acts as 1 and any value above DEPTH acts as DEPTH. `cfg_hold` is latched on `rearm`.
- R3: In the armed and post-trigger states, each beat with `s_valid` high is written at the current write location, and that location then advances by one modulo DEPTH. In the idle state a beat with `s_valid` and `trig` both high is dropped and leaves `armed` at 0.
- R4: A beat with both `s_valid` and `trig` high in the armed state is the trigger sample. It is the first of the post-trigger writes, and `trig_addr` reports the RAM location it was written to.
- R5: After exactly post-length writes counted from the trigger sample, `done` goes to 1 and the write location freezes. Beats offered while `done` is 1 are not stored.
- R6: A read with `rd_en` and `rd_idx` = i returns the content of location (frozen write location + i) mod DEPTH on `rd_data`, with `rd_valid` high, one cycle later. Index 0 is the oldest sample, DEPTH-1 is the newest, and index DEPTH minus post-length is the trigger sample.
- R7: `partial` is set at the trigger when fewer than DEPTH minus post-length samples were written since the block last became armed. Otherwise it is cleared.
- R8: A trigger while `done` is 1 or during hold-off changes neither `done`, `trig_addr` nor the buffer contents.
- R9: A `rearm` pulse while `done` is 1 clears `done`. `armed` then rises after the (hold+1)-th clock edge that follows the edge sampling `rearm`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start waiting from idle |
| rearm | input | 1 | Leave the frozen state through hold-off |
| cfg_post | input | AW+1 | Post-trigger write count, trigger included |
| cfg_hold | input | HW | Hold-off length |
| s_valid | input | 1 | Sample beat valid |
| s_ready | output | 1 | Always 1 |
| s_data | input | DW | Sample value |
| trig | input | 1 | Trigger qualifier for the current beat |
| rd_en | input | 1 | Read request |
| rd_idx | input | AW | Logical index, 0 = oldest |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DW | Read data |
| armed | output | 1 | Waiting for trigger |
| done | output | 1 | Capture frozen and readable |
| partial | output | 1 | Pre-trigger region not fully written |
| trig_addr | output | AW | RAM location of the trigger sample |

## Verification
Captures are driven with a short pre-trigger history, a history longer than the ring, a history exactly at the pre-trigger depth and one sample short of it. This separates a correct `partial` flag from an off-by-one flag. Post lengths of 0, 1, 54 and above DEPTH exercise the clamp and put the trigger at the oldest index, the newest index and an interior index. Hold-off lengths from 0 to 5 are timed, with triggers driven throughout, to detect a hold-off that is too short or that leaks triggers. Beats and triggers sent after freezing confirm that the newest sample and `trig_addr` stay unchanged.

// File: rtl/capbuf_pkg.sv
package capbuf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_POST,
    ST_DONE,
    ST_HOLD
  } cap_state_e;
endpackage

// File: rtl/capbuf_wptr.sv
module capbuf_wptr #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [AW-1:0] wptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)   wptr <= '0;
    else if (adv) wptr <= wptr + 1'b1;
  end
endmodule

// File: rtl/capbuf_ram.sv
module capbuf_ram #(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic          rvalid,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rvalid <= 1'b0;
    else        rvalid <= re;
  end

  a_r6_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    re |=> rvalid);
endmodule

// File: rtl/capbuf_ctrl.sv
module capbuf_ctrl
  import capbuf_pkg::*;
#(
  parameter int AW = 6,
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          rearm,
  input  logic [AW:0]   cfg_post,
  input  logic [HW-1:0] cfg_hold,
  input  logic          s_valid,
  input  logic          trig,
  input  logic [AW-1:0] wptr,
  output logic          we,
  output cap_state_e    st,
  output logic [AW-1:0] trig_addr,
  output logic          partial
);
  localparam int CW = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [CW-1:0] DEPTH_W = CW'(DEPTH);
  localparam logic [CW-1:0] ONE_W   = CW'(1);

  logic [CW-1:0] post_l, rem, prefill;
  logic [HW-1:0] hcnt;

  function automatic logic [CW-1:0] clamp_post(input logic [CW-1:0] v);
    if (v == '0)          return ONE_W;
    else if (v > DEPTH_W) return DEPTH_W;
    else                  return v;
  endfunction

  assign we = s_valid && (st == ST_ARMED || st == ST_POST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      post_l    <= ONE_W;
      rem       <= '0;
      prefill   <= '0;
      hcnt      <= '0;
      trig_addr <= '0;
      partial   <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (arm) begin
          post_l  <= clamp_post(cfg_post);
          prefill <= '0;
          st      <= ST_ARMED;
        end
        ST_ARMED: if (s_valid) begin
          if (trig) begin
            trig_addr <= wptr;
            partial   <= (prefill < (DEPTH_W - post_l));
            rem       <= post_l - ONE_W;
            st        <= (post_l == ONE_W) ? ST_DONE : ST_POST;
          end else if (prefill != DEPTH_W) begin
            prefill <= prefill + ONE_W;
          end
        end
        ST_POST: if (s_valid) begin
          rem <= rem - ONE_W;
          if (rem == ONE_W) st <= ST_DONE;
        end
        ST_DONE: if (rearm) begin
          post_l <= clamp_post(cfg_post);
          hcnt   <= cfg_hold;
          st     <= ST_HOLD;
        end
        ST_HOLD: begin
          if (hcnt == '0) begin
            prefill <= '0;
            st      <= ST_ARMED;
          end else begin
            hcnt <= hcnt - 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  a_r4_wait_without_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ARMED && !(s_valid && trig)) |=> st == ST_ARMED);
  a_r8_holdoff_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOLD) |=> (st == ST_HOLD || st == ST_ARMED));
  a_r8_done_keeps_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DONE) |=> $stable(trig_addr));
endmodule

// File: rtl/capbuf_top.sv
module capbuf_top
  import capbuf_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 6,
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          rearm,
  input  logic [AW:0]   cfg_post,
  input  logic [HW-1:0] cfg_hold,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  input  logic          trig,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_idx,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          armed,
  output logic          done,
  output logic          partial,
  output logic [AW-1:0] trig_addr
);
  cap_state_e    st;
  logic          we;
  logic [AW-1:0] wptr;
  logic [AW-1:0] raddr;

  assign s_ready = 1'b1;
  assign armed   = (st == ST_ARMED);
  assign done    = (st == ST_DONE);
  assign raddr   = wptr + rd_idx;

  capbuf_ctrl #(.AW(AW), .HW(HW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .arm(arm), .rearm(rearm),
    .cfg_post(cfg_post), .cfg_hold(cfg_hold), .s_valid(s_valid),
    .trig(trig), .wptr(wptr), .we(we), .st(st),
    .trig_addr(trig_addr), .partial(partial)
  );

  capbuf_wptr #(.AW(AW)) u_wptr (
    .clk(clk), .rst_n(rst_n), .adv(we), .wptr(wptr)
  );

  capbuf_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(wptr), .wdata(s_data),
    .re(rd_en), .raddr(raddr), .rvalid(rd_valid), .rdata(rd_data)
  );

  a_r5_frozen_pointer: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DONE) |=> $stable(wptr));
  a_r3_hold_no_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOLD) |=> $stable(wptr));
  a_r1_status_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({armed, done}));
endmodule

// File: tb/tb_capbuf_top.sv
module tb_capbuf_top;
  localparam int DW = 8, AW = 6, HW = 8, DEPTH = 1 << AW, NROW = 6;
  localparam int NB_T[NROW]   = '{3, 70, 10, 9, 0, 100};
  localparam int POST_T[NROW] = '{10, 54, 54, 54, 90, 0};
  localparam int HOLD_T[NROW] = '{0, 3, 5, 1, 2, 0};

  logic clk = 1'b0, rst_n = 1'b0, arm = 1'b0, rearm = 1'b0;
  logic [AW:0] cfg_post = '0;
  logic [HW-1:0] cfg_hold = '0;
  logic s_valid = 1'b0, trig = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] s_data = '0;
  logic [AW-1:0] rd_idx = '0;
  logic s_ready, rd_valid, armed, done, partial;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] trig_addr;

  int errs = 0, checks = 0, nw = 0;
  logic [DW-1:0] hist [0:2047];
  bit finished = 0;

  always #10 clk = ~clk;

  capbuf_top #(.DW(DW), .AW(AW), .HW(HW)) dut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .rearm(rearm), .cfg_post(cfg_post),
    .cfg_hold(cfg_hold), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .trig(trig), .rd_en(rd_en), .rd_idx(rd_idx), .rd_valid(rd_valid),
    .rd_data(rd_data), .armed(armed), .done(done), .partial(partial),
    .trig_addr(trig_addr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic t);
    s_valid = 1'b1; trig = t; s_data = DW'(nw * 7 + 3);
    hist[nw] = s_data; nw++;
    @(negedge clk);
    s_valid = 1'b0; trig = 1'b0;
  endtask

  task automatic rd(input int idx, output int v);
    rd_en = 1'b1; rd_idx = AW'(idx);
    @(negedge clk);
    rd_en = 1'b0;
    v = int'(rd_data);
  endtask

  function automatic int eff_post(input int p);
    if (p == 0) return 1;
    if (p > DEPTH) return DEPTH;
    return p;
  endfunction

  task automatic capture(input int nb, input int post);
    int tpos, v;
    for (int i = 0; i < nb; i++) push(1'b0);
    tpos = nw;
    push(1'b1);
    for (int i = 1; i < post; i++) push(1'b0);
    chk("R5 done after post writes", int'(done), 1);
    chk("R7 partial flag", int'(partial), int'(nb < DEPTH - post));
    chk("R4 trigger address", int'(trig_addr), tpos % DEPTH);
    rd(DEPTH - post, v);
    chk("R6 trigger sample at index DEPTH-post", v, int'(hist[tpos]));
    rd(DEPTH - 1, v);
    chk("R6 newest at last index", v, int'(hist[nw-1]));
    if (nw >= DEPTH) begin
      rd(0, v);
      chk("R6 oldest at index 0", v, int'(hist[nw-DEPTH]));
    end
  endtask

  task automatic rearm_and_time(input int hold, input int next_post);
    int n;
    cfg_post = (AW+1)'(next_post); cfg_hold = HW'(hold);
    rearm = 1'b1;
    @(negedge clk);
    rearm = 1'b0;
    chk("R9 done cleared by rearm", int'(done), 0);
    n = 1;
    while (!armed && n < 300) begin
      s_valid = 1'b1; trig = 1'b1; s_data = 8'hEE;
      @(negedge clk);
      n++;
    end
    s_valid = 1'b0; trig = 1'b0;
    chk("R9 hold-off length", n, hold + 2);
    chk("R8 trigger in hold-off ignored", int'(done), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int v, ta, newest;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 armed after reset", int'(armed), 0);
    chk("R1 done after reset", int'(done), 0);
    chk("R1 partial after reset", int'(partial), 0);
    chk("R1 trig_addr after reset", int'(trig_addr), 0);
    chk("R1 s_ready", int'(s_ready), 1);

    // R3: trigger beat in idle is dropped
    s_valid = 1'b1; trig = 1'b1; s_data = 8'h11;
    @(negedge clk);
    s_valid = 1'b0; trig = 1'b0;
    chk("R3 idle beat ignored", int'(armed) + int'(done), 0);

    cfg_post = (AW+1)'(POST_T[0]);
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    chk("R2 armed after arm", int'(armed), 1);

    for (int r = 0; r < NROW; r++) begin
      capture(NB_T[r], eff_post(POST_T[r]));
      rearm_and_time(HOLD_T[r], (r + 1 < NROW) ? POST_T[r+1] : 32);
    end

    // Directed: full history, then frozen-state stimulus
    capture(64, 32);
    ta = int'(trig_addr);
    newest = int'(hist[nw-1]);
    for (int i = 0; i < 5; i++) begin
      s_valid = 1'b1; trig = 1'b1; s_data = 8'hEE;
      @(negedge clk);
    end
    s_valid = 1'b0; trig = 1'b0;
    chk("R8 done stays under trigger", int'(done), 1);
    chk("R8 trig_addr unchanged", int'(trig_addr), ta);
    rd(DEPTH - 1, v);
    chk("R5 frozen beats not stored", v, newest);
    rd_en = 1'b1; rd_idx = '0;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R6 rd_valid one cycle after rd_en", int'(rd_valid), 1);
    @(negedge clk);
    chk("R6 rd_valid drops", int'(rd_valid), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule